// File: doc/BRIEF.md
# Multi-Channel Timer PWM Unit

This block is a bank of independent 16-bit timer channels. Each channel drives one PWM pin. Software programs the block through a simple synchronous register bus. Each channel has:

- a counter;
- a duty ("half") threshold;
- a period ("full") limit;
- a small control field that enables the output, picks the idle level and chooses how the output is shut down.

Two shared strobe addresses start and stop the counters. One address sets run bits and the other clears them, with one bit per channel.

Each channel advances only on a clock-enable tick that comes from outside the block. Generating that tick is the job of the surrounding system, so the block does not divide the clock itself.

A period starts at the idle level. The output takes the opposite level from the duty match until the counter wraps.

When the output is disabled, the shutdown choice applies:

- **Abrupt:** the pin snaps back to the idle level at once.
- **Graceful:** the pin finishes the running period first.

Top module: `tpwm_bank`

## Requirements
- R1: After a synchronous reset, every register is zero. All counters are stopped, every PWM pin and every run bit is low, and reading the status address returns 0.
- R2: Register map and reads:
  - Channel c occupies addresses 4c to 4c+3, holding the counter, half threshold, full limit and control in that order.
  - Control bit 0 is output-enable, bit 1 is idle-level-high and bit 2 is abrupt-shutdown.
  - Address 4·NCH is the run-set strobe and 4·NCH+1 is the run-clear strobe.
  - Read data is registered and appears one cycle after the address. Reading the run-set address returns the run bits in its low NCH bits.
- R3: A counter advances by one only on a cycle where its tick input is high and its run bit is set. Otherwise it holds its value.
- R4: On a tick while the counter equals the full limit, the counter goes to zero and the output returns to the idle level.
- R5: Run strobe writes:
  - A 1 bit written to the run-set address starts that channel's counter.
  - A 1 bit written to the run-clear address stops it.
  - 0 bits leave the other channels unchanged.
- R6: A bus write to a counter loads the written value and wins over a tick in the same cycle. The output then shows the idle level unless the written value equals the half threshold.
- R7: With output enabled, the pin holds the idle level from the period start until the counter equals the half threshold. It then holds the opposite level up to and including the full limit. The pin is registered and changes in the same cycle as the counter.
- R8: If the half threshold is greater than the full limit, the output stays at the idle level for the whole period.
- R9: With output-enable clear (and no graceful shutdown pending), the pin sits at the idle level chosen by the idle-level-high bit.
- R10: Clearing output-enable with abrupt-shutdown set puts the pin at the idle level in the next cycle.
- R11: Clearing output-enable with abrupt-shutdown clear keeps the waveform running until the next wrap. After that the pin stays at the idle level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| tick_i | input | NCH | Per-channel count-enable tick |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | AW | Register address |
| bus_wdata | input | CW | Write data |
| bus_rdata | output | CW | Registered read data (one-cycle latency) |
| pwm_o | output | NCH | Registered PWM pin levels |
| run_o | output | NCH | Counter run status |

## Verification
A software write to a counter and a count tick can land on the same clock edge, and the write has to win.

The bench provokes this by:

1. holding the tick high;
2. issuing the counter write in the middle of the run;
3. reading the counter back, expecting exactly the written value rather than that value plus one;
4. checking that the pin matches the written position.

A second collision is the output-enable write landing on a counting edge. In that case the abrupt and graceful endings are judged cycle by cycle against a period model built from the requirements.

// File: rtl/tpwm_pkg.sv
`timescale 1ns/1ps
package tpwm_pkg;
  localparam int CTRL_W = 3;
  localparam int CB_EN  = 0;
  localparam int CB_HI  = 1;
  localparam int CB_ABR = 2;

  localparam logic [1:0] SEL_CNT  = 2'd0;
  localparam logic [1:0] SEL_HALF = 2'd1;
  localparam logic [1:0] SEL_FULL = 2'd2;
  localparam logic [1:0] SEL_CTRL = 2'd3;
endpackage

// File: rtl/tpwm_runctl.sv
`timescale 1ns/1ps
module tpwm_runctl #(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           set_stb_i,
  input  logic           clr_stb_i,
  input  logic [NCH-1:0] mask_i,
  output logic [NCH-1:0] run_q
);
  always_ff @(posedge clk) begin
    if (rst) run_q <= '0;
    else if (set_stb_i) run_q <= run_q | mask_i;
    else if (clr_stb_i) run_q <= run_q & ~mask_i;
  end

  a_r5_set_starts: assert property (@(posedge clk) disable iff (rst)
    set_stb_i |=> ((run_q & $past(mask_i)) == $past(mask_i)));
  a_r5_clr_stops: assert property (@(posedge clk) disable iff (rst)
    clr_stb_i |=> ((run_q & $past(mask_i)) == '0));
  a_r5_zero_bits_kept: assert property (@(posedge clk) disable iff (rst)
    (set_stb_i || clr_stb_i) |=> (((run_q ^ $past(run_q)) & ~$past(mask_i)) == '0));
endmodule

// File: rtl/tpwm_regif.sv
`timescale 1ns/1ps
module tpwm_regif
  import tpwm_pkg::*;
#(
  parameter int NCH = 4,
  parameter int DW  = 16,
  parameter int AW  = 5
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         bus_we,
  input  logic [AW-1:0]                bus_addr,
  input  logic [NCH-1:0]               run_i,
  input  logic [NCH-1:0][DW-1:0]       cnt_i,
  input  logic [NCH-1:0][DW-1:0]       half_i,
  input  logic [NCH-1:0][DW-1:0]       full_i,
  input  logic [NCH-1:0][CTRL_W-1:0]   ctrl_i,
  output logic [NCH-1:0]               cnt_we_o,
  output logic [NCH-1:0]               half_we_o,
  output logic [NCH-1:0]               full_we_o,
  output logic [NCH-1:0]               ctrl_we_o,
  output logic                         set_stb_o,
  output logic                         clr_stb_o,
  output logic [DW-1:0]                rdata_o
);
  localparam int CHW      = AW - 2;
  localparam int SET_ADDR = NCH * 4;
  localparam int CLR_ADDR = NCH * 4 + 1;

  logic [1:0]     sel;
  logic [NCH-1:0] ch_hit;
  logic [DW-1:0]  rd_n;

  assign sel = bus_addr[1:0];

  for (genvar i = 0; i < NCH; i++) begin : g_dec
    assign ch_hit[i]    = (bus_addr[AW-1:2] == CHW'(i));
    assign cnt_we_o[i]  = bus_we & ch_hit[i] & (sel == SEL_CNT);
    assign half_we_o[i] = bus_we & ch_hit[i] & (sel == SEL_HALF);
    assign full_we_o[i] = bus_we & ch_hit[i] & (sel == SEL_FULL);
    assign ctrl_we_o[i] = bus_we & ch_hit[i] & (sel == SEL_CTRL);
  end

  assign set_stb_o = bus_we & (bus_addr == AW'(SET_ADDR));
  assign clr_stb_o = bus_we & (bus_addr == AW'(CLR_ADDR));

  always_comb begin
    rd_n = '0;
    if (bus_addr == AW'(SET_ADDR)) rd_n[NCH-1:0] = run_i;
    for (int i = 0; i < NCH; i++) begin
      if (ch_hit[i]) begin
        case (sel)
          SEL_CNT:  rd_n = cnt_i[i];
          SEL_HALF: rd_n = half_i[i];
          SEL_FULL: rd_n = full_i[i];
          default:  rd_n = DW'(ctrl_i[i]);
        endcase
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_o <= '0;
    else     rdata_o <= rd_n;
  end

  a_r2_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
    $countones({set_stb_o, clr_stb_o, cnt_we_o, half_we_o, full_we_o, ctrl_we_o}) <= 1);
endmodule

// File: rtl/tpwm_chan.sv
`timescale 1ns/1ps
module tpwm_chan
  import tpwm_pkg::*;
#(
  parameter int CW = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tick_i,
  input  logic              run_i,
  input  logic              cnt_we,
  input  logic              half_we,
  input  logic              full_we,
  input  logic              ctrl_we,
  input  logic [CW-1:0]     wdata_i,
  output logic [CW-1:0]     cnt_q,
  output logic [CW-1:0]     half_q,
  output logic [CW-1:0]     full_q,
  output logic [CTRL_W-1:0] ctrl_q,
  output logic              pwm_o
);
  logic              fl_q, fl_n;
  logic              dr_q, dr_n;
  logic              adv, wrap, pwm_n;
  logic [CW-1:0]     cnt_n;
  logic [CTRL_W-1:0] ctrl_n;

  always_comb begin
    adv   = run_i & tick_i;
    wrap  = adv & ~cnt_we & (cnt_q == full_q);
    cnt_n = cnt_q;
    fl_n  = fl_q;
    if (cnt_we) begin
      cnt_n = wdata_i;
      fl_n  = (wdata_i == half_q);
    end else if (adv) begin
      cnt_n = wrap ? '0 : cnt_q + 1'b1;
      fl_n  = (cnt_n == half_q) | (fl_q & ~wrap);
    end

    ctrl_n = ctrl_we ? wdata_i[CTRL_W-1:0] : ctrl_q;

    if (ctrl_n[CB_EN])                         dr_n = 1'b0;
    else if (ctrl_q[CB_EN] && !ctrl_n[CB_ABR]) dr_n = 1'b1;
    else if (wrap)                             dr_n = 1'b0;
    else                                       dr_n = dr_q;

    pwm_n = (ctrl_n[CB_EN] | dr_n) ? (ctrl_n[CB_HI] ^ fl_n) : ctrl_n[CB_HI];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      half_q <= '0;
      full_q <= '0;
      ctrl_q <= '0;
      fl_q   <= 1'b0;
      dr_q   <= 1'b0;
      pwm_o  <= 1'b0;
    end else begin
      cnt_q  <= cnt_n;
      ctrl_q <= ctrl_n;
      fl_q   <= fl_n;
      dr_q   <= dr_n;
      pwm_o  <= pwm_n;
      if (half_we) half_q <= wdata_i;
      if (full_we) full_q <= wdata_i;
    end
  end

  a_r3_hold_when_idle: assert property (@(posedge clk) disable iff (rst)
    (!(run_i && tick_i) && !cnt_we) |=> $stable(cnt_q));
  a_r4_wrap_to_zero: assert property (@(posedge clk) disable iff (rst)
    (run_i && tick_i && !cnt_we && (cnt_q == full_q)) |=> (cnt_q == '0));
  a_r6_write_wins: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> (cnt_q == $past(wdata_i)));
  a_r10_abrupt_idle: assert property (@(posedge clk) disable iff (rst)
    (ctrl_we && ctrl_q[CB_EN] && !wdata_i[CB_EN] && wdata_i[CB_ABR])
      |=> (pwm_o == ctrl_q[CB_HI]));
endmodule

// File: rtl/tpwm_bank.sv
`timescale 1ns/1ps
module tpwm_bank
  import tpwm_pkg::*;
#(
  parameter  int NCH = 4,
  parameter  int CW  = 16,
  localparam int AW  = $clog2(NCH * 4 + 2)
) (
  input  logic           clk,
  input  logic           rst,
  input  logic [NCH-1:0] tick_i,
  input  logic           bus_we,
  input  logic [AW-1:0]  bus_addr,
  input  logic [CW-1:0]  bus_wdata,
  output logic [CW-1:0]  bus_rdata,
  output logic [NCH-1:0] pwm_o,
  output logic [NCH-1:0] run_o
);
  logic [NCH-1:0][CW-1:0]     cnt_v, half_v, full_v;
  logic [NCH-1:0][CTRL_W-1:0] ctrl_v;
  logic [NCH-1:0]             cnt_we, half_we, full_we, ctrl_we;
  logic                       set_stb, clr_stb;

  tpwm_regif #(.NCH(NCH), .DW(CW), .AW(AW)) u_regif (
    .clk       (clk),
    .rst       (rst),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .run_i     (run_o),
    .cnt_i     (cnt_v),
    .half_i    (half_v),
    .full_i    (full_v),
    .ctrl_i    (ctrl_v),
    .cnt_we_o  (cnt_we),
    .half_we_o (half_we),
    .full_we_o (full_we),
    .ctrl_we_o (ctrl_we),
    .set_stb_o (set_stb),
    .clr_stb_o (clr_stb),
    .rdata_o   (bus_rdata)
  );

  tpwm_runctl #(.NCH(NCH)) u_run (
    .clk       (clk),
    .rst       (rst),
    .set_stb_i (set_stb),
    .clr_stb_i (clr_stb),
    .mask_i    (bus_wdata[NCH-1:0]),
    .run_q     (run_o)
  );

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    tpwm_chan #(.CW(CW)) u_ch (
      .clk     (clk),
      .rst     (rst),
      .tick_i  (tick_i[i]),
      .run_i   (run_o[i]),
      .cnt_we  (cnt_we[i]),
      .half_we (half_we[i]),
      .full_we (full_we[i]),
      .ctrl_we (ctrl_we[i]),
      .wdata_i (bus_wdata),
      .cnt_q   (cnt_v[i]),
      .half_q  (half_v[i]),
      .full_q  (full_v[i]),
      .ctrl_q  (ctrl_v[i]),
      .pwm_o   (pwm_o[i])
    );
  end

  a_r1_reset_quiet: assert property (@(posedge clk)
    $past(rst) |-> (pwm_o == '0 && run_o == '0 && bus_rdata == '0));
endmodule

// File: tb/sim_tpwm_bank.sv
`timescale 1ns/1ps
module sim_tpwm_bank;
  localparam int NCH = 4;
  localparam int CW  = 16;
  localparam int AW  = $clog2(NCH * 4 + 2);
  localparam int SET_A = NCH * 4;
  localparam int CLR_A = NCH * 4 + 1;

  logic           clk = 1'b0;
  logic           rst;
  logic [NCH-1:0] tick_i;
  logic           bus_we;
  logic [AW-1:0]  bus_addr;
  logic [CW-1:0]  bus_wdata;
  logic [CW-1:0]  bus_rdata;
  logic [NCH-1:0] pwm_o;
  logic [NCH-1:0] run_o;

  tpwm_bank #(.NCH(NCH), .CW(CW)) u0 (
    .clk(clk), .rst(rst), .tick_i(tick_i), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pwm_o(pwm_o), .run_o(run_o)
  );

  always #10 clk = ~clk;

  int nchk = 0;
  int nfail = 0;
  bit finished = 0;

  typedef struct {
    string       tag;
    logic [15:0] exp;
  } item_t;
  item_t sb_q[$];
  event  rd_ev;

  // model of channel 0, built from the requirements
  int m_c, m_half, m_full;
  bit m_init, m_en, m_drain, m_run;

  task automatic chk(input logic [15:0] act, input logic [15:0] exp, input string tag);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  // monitor: pops expected read data as results appear
  initial begin
    forever begin
      item_t it;
      @(rd_ev);
      it = sb_q.pop_front();
      chk(bus_rdata, it.exp, it.tag);
    end
  end

  task automatic wr(input int a, input int d);
    @(negedge clk);
    bus_we = 1'b1; bus_addr = a[AW-1:0]; bus_wdata = d[CW-1:0];
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input int a, input int e, input string tag);
    item_t it;
    @(negedge clk);
    bus_addr = a[AW-1:0];
    it.tag = tag; it.exp = e[15:0];
    sb_q.push_back(it);
    @(negedge clk);
    -> rd_ev;
    #1;
  endtask

  task automatic step();
    bit wrap;
    if (m_run) begin
      wrap = (m_c == m_full);
      m_c  = wrap ? 0 : m_c + 1;
      if (wrap) m_drain = 0;
    end
  endtask

  function automatic logic [15:0] exp_pwm();
    bit fl;
    fl = (m_half <= m_full) && (m_c >= m_half);
    return ((m_en || m_drain) ? (m_init ^ fl) : m_init) ? 16'd1 : 16'd0;
  endfunction

  task automatic run_ck(input int n, input bit keep, input string tag);
    tick_i[0] = 1'b1;
    for (int k = 0; k < n; k++) begin
      @(negedge clk);
      step();
      chk({15'd0, pwm_o[0]}, exp_pwm(), tag);
    end
    if (!keep) tick_i[0] = 1'b0;
  endtask

  task automatic cfg(input int h, input int f, input int c);
    wr(1, h); wr(2, f);
    if (c[0]) m_drain = 0;
    else if (m_en && !c[2]) m_drain = 1;
    m_en = c[0]; m_init = c[1]; m_half = h; m_full = f;
    wr(3, c);
    wr(0, 0);
    m_c = 0;
  endtask

  initial begin
    rst = 1'b1; tick_i = '0; bus_we = 1'b0; bus_addr = '0; bus_wdata = '0;
    m_c = 0; m_half = 0; m_full = 0; m_init = 0; m_en = 0; m_drain = 0; m_run = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    chk({12'd0, pwm_o}, 16'd0, "R1 pwm low");
    chk({12'd0, run_o}, 16'd0, "R1 run bits");
    rd(SET_A, 0, "R1 status");
    rd(0, 0, "R1 counter");

    // R2 register map readback
    cfg(3, 5, 1);
    rd(1, 3, "R2 half");
    rd(2, 5, "R2 full");
    rd(3, 1, "R2 ctrl");

    // R3 no counting while stopped
    run_ck(4, 0, "R3 stopped pwm");
    rd(0, 0, "R3 counter held");

    // R5 start channel 0
    wr(SET_A, 1); m_run = 1;
    rd(SET_A, 1, "R5 set ch0");

    // R7 / R4 waveform and wrap
    run_ck(14, 0, "R7 waveform");
    rd(0, m_c, "R4 counter after wrap");

    // R8 half above full
    cfg(7, 5, 1);
    run_ck(8, 0, "R8 no match");

    // R7 idle-high
    cfg(2, 4, 3);
    run_ck(10, 0, "R7 idle high");

    // R6 counter write collides with tick
    cfg(3, 5, 1);
    run_ck(1, 1, "R6 pre");
    bus_we = 1'b1; bus_addr = AW'(0); bus_wdata = 16'd2;
    @(negedge clk);
    bus_we = 1'b0; tick_i[0] = 1'b0; m_c = 2;
    chk({15'd0, pwm_o[0]}, exp_pwm(), "R6 pwm after load");
    rd(0, 2, "R6 write wins");

    // R5 set/clear with zero bits
    wr(SET_A, 2);
    rd(SET_A, 3, "R5 set ch1");
    wr(CLR_A, 2);
    rd(SET_A, 1, "R5 zero bits kept");
    wr(CLR_A, 1); m_run = 0;
    rd(SET_A, 0, "R5 clear ch0");
    run_ck(5, 0, "R3 stopped again");
    rd(0, 2, "R3 value held");
    wr(SET_A, 1); m_run = 1;

    // R10 abrupt shutdown
    cfg(1, 9, 5);
    run_ck(3, 1, "R10 pre");
    bus_we = 1'b1; bus_addr = AW'(3); bus_wdata = 16'd4;
    m_en = 0; m_drain = 0;
    @(negedge clk);
    bus_we = 1'b0; step();
    chk({15'd0, pwm_o[0]}, exp_pwm(), "R10 abrupt idle");
    run_ck(4, 0, "R10 stays idle");

    // R11 graceful shutdown
    cfg(1, 9, 1);
    run_ck(3, 1, "R11 pre");
    bus_we = 1'b1; bus_addr = AW'(3); bus_wdata = 16'd0;
    m_en = 0; m_drain = 1;
    @(negedge clk);
    bus_we = 1'b0; step();
    chk({15'd0, pwm_o[0]}, exp_pwm(), "R11 still active");
    run_ck(12, 0, "R11 finishes period");

    // R9 output disabled, idle level selectable
    cfg(1, 4, 2);
    run_ck(8, 0, "R9 idle high");
    cfg(1, 4, 0);
    run_ck(3, 0, "R9 idle low");

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      nchk++; nfail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end
endmodule